// File: doc/BRIEF.md
# Cut-Through Word-Stream Packet Switch

This block joins four 32-bit word streams to four 32-bit word streams. Every packet starts with one header word. The header names the endpoint the packet is going to, the endpoint that sent it, and how many payload words follow. When a header arrives at an input, the switch looks up the destination in a fixed address table and claims the matching output. It keeps that output for the header and all the payload words, then frees it.

Words pass straight through a combinational crossbar, so a packet is never stored inside the switch. Inputs that want different outputs move forward in the same cycle. When several idle inputs want one free output, the input with the lowest index wins. The other inputs are held back with ready low. Every input and every output uses a valid/ready handshake for each word, so a slow receiver stalls its sender and no word is dropped.

Top module: `cts_switch`

## Requirements
- R1: While reset is asserted, and after reset with no input valid, every `outValid` and every `inReady` bit is low.
- R2: A header word is laid out as destination ID in bits [31:24], source ID in bits [23:16] and payload length in words in bits [15:0]. A destination ID equal to `ID_BASE + p` (default 0x10 to 0x13) selects output p. The header and its payload words appear at that output unchanged and in order.
- R3: A destination ID outside the range `ID_BASE` to `ID_BASE + 3` (for example 0x7F, or 0x0F, which sits just below the range) sends the packet to output 0.
- R4: An output stays with one packet for exactly its header plus its length field in words. It is released after the last word is accepted, or after the header alone when the length is 0. A header waiting for that output is accepted on the next cycle.
- R5: Headers from idle inputs that target different free outputs are all accepted in the same cycle. Their payloads then stream at the same time.
- R6: When two or more idle inputs present headers for the same free output in the same cycle, the lowest-numbered input wins. Only one header is accepted per output per cycle.
- R7: Once an output is granted, no other input can take it before the packet ends, not even an input with a lower index. A losing or late input keeps `inReady` low until the output is released.
- R8: An input's `inReady` is high only while its output's `outReady` is high. Every accepted input word appears as exactly one accepted output word. While the output is stalled, it holds its valid and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 4 | Per-input word valid |
| inData | input | 4 x 32 | Per-input word; the first word of a packet is the header |
| inReady | output | 4 | Per-input word accepted when high together with valid |
| outValid | output | 4 | Per-output word valid |
| outData | output | 4 x 32 | Per-output word |
| outReady | input | 4 | Per-output receiver ready |

## Verification
The assertions check four things on every cycle:
- Words are conserved, both in number and in content (an XOR fold), between the inputs and the outputs.
- Header boundaries line up on both sides.
- Every header that leaves an output carries a destination that belongs to that output, or is unknown and leaves on output 0.
- No two headers are accepted for the same output in one cycle.

Other behaviour can only be shown by the bench scenarios, because it depends on timing between packets:
- which contender wins,
- that a high-priority latecomer waits exactly until the length field runs out,
- that a zero-length packet frees the output after one cycle,
- that stalled words are held rather than lost.

// File: rtl/cts_pkg.sv
`timescale 1ns/100ps
package cts_pkg;
  localparam int PORT_CNT = 4;
  localparam int WORD_W = 32;
  localparam int ID_W = 8;
  localparam int LEN_W = 16;
  localparam int IDX_W = $clog2(PORT_CNT);
  localparam int CNT_W = LEN_W + 1;
  localparam int DEFAULT_PORT = 0;
  localparam logic [ID_W-1:0] DEF_ID_BASE = 8'h10;

  typedef struct packed {
    logic [ID_W-1:0] dst;
    logic [ID_W-1:0] src;
    logic [LEN_W-1:0] len;
  } hdr_t;

  // Strobes from control to the crossbar, one entry per port index.
  typedef struct packed {
    logic outEn;
    logic [IDX_W-1:0] outSel;
    logic inEn;
    logic [IDX_W-1:0] inRoute;
  } portCtl_t;

  function automatic logic [IDX_W-1:0] oneHotIdx(input logic [PORT_CNT-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int k = 0; k < PORT_CNT; k++)
      if (v[k]) idx = idx | IDX_W'(k);
    return idx;
  endfunction
endpackage

// File: rtl/cts_pkt_tracker.sv
`timescale 1ns/100ps
module cts_pkt_tracker import cts_pkg::*; (
  input  logic clk,
  input  logic rstN,
  input  logic grant,
  input  logic fire,
  input  logic [LEN_W-1:0] len,
  input  logic [IDX_W-1:0] route,
  output logic busy,
  output logic busyNxt,
  output logic [IDX_W-1:0] routeQ
);
  // Words still owed by the packet on this input, header included.
  logic [CNT_W-1:0] leftQ, leftNxt;

  always_comb begin
    leftNxt = leftQ;
    if (grant)
      leftNxt = CNT_W'(len) + CNT_W'(1) - CNT_W'(fire);
    else if (busy && fire)
      leftNxt = leftQ - CNT_W'(1);
  end

  assign busy = (leftQ != '0);
  assign busyNxt = (leftNxt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftQ <= '0;
      routeQ <= '0;
    end else begin
      leftQ <= leftNxt;
      if (grant) routeQ <= route;
    end
  end
endmodule

// File: rtl/cts_ctrl.sv
`timescale 1ns/100ps
module cts_ctrl import cts_pkg::*; #(
  parameter logic [ID_W-1:0] ID_BASE = DEF_ID_BASE
) (
  input  logic clk,
  input  logic rstN,
  input  logic [PORT_CNT-1:0] inValid,
  input  logic [PORT_CNT-1:0] inFire,
  input  logic [PORT_CNT-1:0][ID_W-1:0] inDst,
  input  logic [PORT_CNT-1:0][LEN_W-1:0] inLen,
  output portCtl_t [PORT_CNT-1:0] ctl
);
  logic [PORT_CNT-1:0] inBusy, inBusyNxt, newGrant;
  logic [PORT_CNT-1:0][IDX_W-1:0] dstPort, inRouteQ;
  logic [PORT_CNT-1:0][PORT_CNT-1:0] reqMask, grantOh;
  logic [PORT_CNT-1:0] outBusyQ, outBusyNxt;
  logic [PORT_CNT-1:0][IDX_W-1:0] outOwnerQ;

  // Fixed address table: contiguous IDs from ID_BASE, anything else to the default port.
  for (genvar i = 0; i < PORT_CNT; i++) begin : g_decode
    logic [ID_W-1:0] offs;
    assign offs = inDst[i] - ID_BASE;
    assign dstPort[i] = (offs < ID_W'(PORT_CNT)) ? offs[IDX_W-1:0] : IDX_W'(DEFAULT_PORT);
  end

  // Fixed priority per output: lowest input index among idle requesters.
  for (genvar o = 0; o < PORT_CNT; o++) begin : g_arb
    always_comb begin
      for (int i = 0; i < PORT_CNT; i++)
        reqMask[o][i] = inValid[i] && !inBusy[i] && (dstPort[i] == IDX_W'(o));
    end
    assign grantOh[o] = outBusyQ[o] ? '0 : (reqMask[o] & (~reqMask[o] + PORT_CNT'(1)));
  end

  always_comb begin
    for (int i = 0; i < PORT_CNT; i++) begin
      newGrant[i] = 1'b0;
      for (int o = 0; o < PORT_CNT; o++)
        newGrant[i] = newGrant[i] | grantOh[o][i];
    end
  end

  for (genvar i = 0; i < PORT_CNT; i++) begin : g_track
    cts_pkt_tracker u_track (
      .clk(clk),
      .rstN(rstN),
      .grant(newGrant[i]),
      .fire(inFire[i]),
      .len(inLen[i]),
      .route(dstPort[i]),
      .busy(inBusy[i]),
      .busyNxt(inBusyNxt[i]),
      .routeQ(inRouteQ[i])
    );
  end

  always_comb begin
    for (int p = 0; p < PORT_CNT; p++) begin
      ctl[p].outEn = outBusyQ[p] | (|grantOh[p]);
      ctl[p].outSel = outBusyQ[p] ? outOwnerQ[p] : oneHotIdx(grantOh[p]);
      ctl[p].inEn = inBusy[p] | newGrant[p];
      ctl[p].inRoute = inBusy[p] ? inRouteQ[p] : dstPort[p];
    end
  end

  always_comb begin
    for (int o = 0; o < PORT_CNT; o++)
      outBusyNxt[o] = ctl[o].outEn && inBusyNxt[ctl[o].outSel];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBusyQ <= '0;
      outOwnerQ <= '0;
    end else begin
      outBusyQ <= outBusyNxt;
      for (int o = 0; o < PORT_CNT; o++)
        if (ctl[o].outEn) outOwnerQ[o] <= ctl[o].outSel;
    end
  end
endmodule

// File: rtl/cts_datapath.sv
`timescale 1ns/100ps
module cts_datapath import cts_pkg::*; (
  input  logic [PORT_CNT-1:0] inValid,
  input  logic [PORT_CNT-1:0][WORD_W-1:0] inData,
  output logic [PORT_CNT-1:0] inReady,
  output logic [PORT_CNT-1:0] outValid,
  output logic [PORT_CNT-1:0][WORD_W-1:0] outData,
  input  logic [PORT_CNT-1:0] outReady,
  input  portCtl_t [PORT_CNT-1:0] ctl,
  output logic [PORT_CNT-1:0] inFire,
  output logic [PORT_CNT-1:0][ID_W-1:0] inDst,
  output logic [PORT_CNT-1:0][LEN_W-1:0] inLen
);
  for (genvar o = 0; o < PORT_CNT; o++) begin : g_out
    assign outValid[o] = ctl[o].outEn & inValid[ctl[o].outSel];
    assign outData[o] = ctl[o].outEn ? inData[ctl[o].outSel] : '0;
  end

  for (genvar i = 0; i < PORT_CNT; i++) begin : g_in
    hdr_t hdrView;
    assign hdrView = hdr_t'(inData[i]);
    assign inDst[i] = hdrView.dst;
    assign inLen[i] = hdrView.len;
    assign inReady[i] = ctl[i].inEn & outReady[ctl[i].inRoute];
  end

  assign inFire = inValid & inReady;
endmodule

// File: rtl/cts_switch.sv
`timescale 1ns/100ps
module cts_switch import cts_pkg::*; #(
  parameter logic [ID_W-1:0] ID_BASE = DEF_ID_BASE
) (
  input  logic clk,
  input  logic rstN,
  input  logic [PORT_CNT-1:0] inValid,
  input  logic [PORT_CNT-1:0][WORD_W-1:0] inData,
  output logic [PORT_CNT-1:0] inReady,
  output logic [PORT_CNT-1:0] outValid,
  output logic [PORT_CNT-1:0][WORD_W-1:0] outData,
  input  logic [PORT_CNT-1:0] outReady
);
  portCtl_t [PORT_CNT-1:0] ctl;
  logic [PORT_CNT-1:0] inFire;
  logic [PORT_CNT-1:0][ID_W-1:0] inDst;
  logic [PORT_CNT-1:0][LEN_W-1:0] inLen;

  cts_ctrl #(.ID_BASE(ID_BASE)) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .inValid(inValid),
    .inFire(inFire),
    .inDst(inDst),
    .inLen(inLen),
    .ctl(ctl)
  );

  cts_datapath u_dp (
    .inValid(inValid),
    .inData(inData),
    .inReady(inReady),
    .outValid(outValid),
    .outData(outData),
    .outReady(outReady),
    .ctl(ctl),
    .inFire(inFire),
    .inDst(inDst),
    .inLen(inLen)
  );
endmodule

// File: rtl/cts_switch_checker.sv
`timescale 1ns/100ps
module cts_switch_checker import cts_pkg::*; #(
  parameter logic [ID_W-1:0] ID_BASE = DEF_ID_BASE
) (
  input logic clk,
  input logic rstN,
  input logic [PORT_CNT-1:0] inValid,
  input logic [PORT_CNT-1:0][WORD_W-1:0] inData,
  input logic [PORT_CNT-1:0] inReady,
  input logic [PORT_CNT-1:0] outValid,
  input logic [PORT_CNT-1:0][WORD_W-1:0] outData,
  input logic [PORT_CNT-1:0] outReady
);
  logic [PORT_CNT-1:0] inFire, outFire, inHdrFire, outHdrFire;
  logic [PORT_CNT-1:0][LEN_W-1:0] inLeft, outLeft;
  logic [PORT_CNT-1:0][PORT_CNT-1:0] hdrToPort;
  logic [WORD_W-1:0] inFold, outFold;

  function automatic logic inTable(input logic [WORD_W-1:0] w);
    logic [ID_W-1:0] d;
    d = w[WORD_W-1 -: ID_W] - ID_BASE;
    return d < ID_W'(PORT_CNT);
  endfunction

  function automatic logic [IDX_W-1:0] portOf(input logic [WORD_W-1:0] w);
    logic [ID_W-1:0] d;
    d = w[WORD_W-1 -: ID_W] - ID_BASE;
    return inTable(w) ? d[IDX_W-1:0] : IDX_W'(DEFAULT_PORT);
  endfunction

  assign inFire = inValid & inReady;
  assign outFire = outValid & outReady;

  always_comb begin
    inFold = '0;
    outFold = '0;
    for (int p = 0; p < PORT_CNT; p++) begin
      inHdrFire[p] = inFire[p] && (inLeft[p] == '0);
      outHdrFire[p] = outFire[p] && (outLeft[p] == '0);
      if (inFire[p]) inFold = inFold ^ inData[p];
      if (outFire[p]) outFold = outFold ^ outData[p];
    end
    for (int o = 0; o < PORT_CNT; o++)
      for (int i = 0; i < PORT_CNT; i++)
        hdrToPort[o][i] = inHdrFire[i] && (portOf(inData[i]) == IDX_W'(o));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inLeft <= '0;
      outLeft <= '0;
    end else begin
      for (int p = 0; p < PORT_CNT; p++) begin
        if (inFire[p])
          inLeft[p] <= (inLeft[p] == '0) ? inData[p][LEN_W-1:0] : inLeft[p] - LEN_W'(1);
        if (outFire[p])
          outLeft[p] <= (outLeft[p] == '0) ? outData[p][LEN_W-1:0] : outLeft[p] - LEN_W'(1);
      end
    end
  end

  assert_word_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(inFire) == $countones(outFire));

  assert_word_content_R8: assert property (@(posedge clk) disable iff (!rstN)
    inFold == outFold);

  assert_header_align_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(inHdrFire) == $countones(outHdrFire));

  for (genvar o = 0; o < PORT_CNT; o++) begin : g_port
    assert_route_R2: assert property (@(posedge clk) disable iff (!rstN)
      (outHdrFire[o] && inTable(outData[o])) |-> (portOf(outData[o]) == IDX_W'(o)));

    assert_default_R3: assert property (@(posedge clk) disable iff (!rstN)
      (outHdrFire[o] && !inTable(outData[o])) |-> (IDX_W'(o) == IDX_W'(DEFAULT_PORT)));

    assert_one_winner_R6: assert property (@(posedge clk) disable iff (!rstN)
      $countones(hdrToPort[o]) <= 1);
  end
endmodule

bind cts_switch cts_switch_checker #(.ID_BASE(ID_BASE)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .inValid(inValid),
  .inData(inData),
  .inReady(inReady),
  .outValid(outValid),
  .outData(outData),
  .outReady(outReady)
);

// File: tb/cts_switch_bench.sv
`timescale 1ns/100ps
module cts_switch_bench;
  import cts_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PORT_CNT-1:0] inValid = '0;
  logic [PORT_CNT-1:0][WORD_W-1:0] inData = '0;
  logic [PORT_CNT-1:0] inReady;
  logic [PORT_CNT-1:0] outValid;
  logic [PORT_CNT-1:0][WORD_W-1:0] outData;
  logic [PORT_CNT-1:0] outReady = '1;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int hdrCyc [PORT_CNT];
  logic [WORD_W-1:0] expQ [PORT_CNT][$];
  string reqQ [PORT_CNT][$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cts_switch u_cts_switch (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #0.5;
  endtask

  function automatic int expPort(input logic [7:0] dst);
    logic [7:0] d;
    d = dst - 8'h10;
    return (d < 8'd4) ? int'(d) : 0;
  endfunction

  // Driver: offers header then payload; queues the whole packet once its header is taken.
  task automatic sendPkt(input int p, input logic [7:0] dst, input int len, input logic [7:0] tag, input string req);
    int ep;
    logic [31:0] w;
    ep = expPort(dst);
    for (int k = 0; k <= len; k++) begin
      w = (k == 0) ? {dst, 8'(p), 16'(len)} : {tag, 8'(p), 16'(k)};
      inValid[p] = 1'b1;
      inData[p] = w;
      @(negedge clk);
      while (!inReady[p]) @(negedge clk);
      if (k == 0) begin
        hdrCyc[p] = cyc;
        for (int m = 0; m <= len; m++) begin
          expQ[ep].push_back((m == 0) ? w : {tag, 8'(p), 16'(m)});
          reqQ[ep].push_back(req);
        end
      end
      @(posedge clk);
      #0.5;
    end
    inValid[p] = 1'b0;
    inData[p] = '0;
  endtask

  // Monitor: compares every accepted output word with the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #0.5;
      if (rstN) begin
        for (int o = 0; o < PORT_CNT; o++) begin
          if (outValid[o] && outReady[o]) begin
            if (expQ[o].size() == 0) begin
              checks++;
              fails++;
              $display("FAIL R2 unexpected word on port %0d: actual %h expected none", o, outData[o]);
            end else begin
              logic [31:0] w;
              string r;
              w = expQ[o].pop_front();
              r = reqQ[o].pop_front();
              chk(r, $sformatf("port %0d word", o), outData[o], w);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1", "outValid in reset", 32'(outValid), 32'h0);
    chk("R1", "inReady in reset", 32'(inReady), 32'h0);
    rstN = 1'b1;
    tick(2);
    chk("R1", "outValid after reset", 32'(outValid), 32'h0);
    chk("R1", "inReady after reset", 32'(inReady), 32'h0);

    // R2: each input to its neighbour's output
    for (int p = 0; p < PORT_CNT; p++)
      sendPkt(p, 8'(8'h10 + ((p + 1) % PORT_CNT)), 3, 8'hA0 + 8'(p), "R2");
    tick(2);

    // R3: IDs outside the table land on port 0
    sendPkt(2, 8'h7F, 2, 8'hB1, "R3");
    sendPkt(3, 8'h0F, 1, 8'hB2, "R3");
    tick(2);

    // R4: zero-length packet frees the output after its header
    fork
      sendPkt(1, 8'h13, 0, 8'hC1, "R4");
      sendPkt(2, 8'h13, 2, 8'hC2, "R4");
    join
    chk("R4", "zero-length release gap", 32'(hdrCyc[2] - hdrCyc[1]), 32'd1);
    tick(2);

    // R7: higher-priority input waits out a packet in progress
    fork
      sendPkt(3, 8'h11, 6, 8'hD3, "R7");
      begin
        tick(2);
        chk("R7", "late input held", 32'(inReady[0]), 32'd0);
        sendPkt(0, 8'h11, 1, 8'hD0, "R7");
      end
    join
    chk("R7", "wait until release", 32'(hdrCyc[0] - hdrCyc[3]), 32'd7);
    tick(2);

    // R6: simultaneous contenders for port 2
    fork
      sendPkt(3, 8'h12, 2, 8'hE3, "R6");
      sendPkt(1, 8'h12, 2, 8'hE1, "R6");
    join
    chk("R6", "lower index first", 32'(hdrCyc[3] - hdrCyc[1]), 32'd3);
    tick(2);

    // R5: four disjoint packets in parallel
    fork
      sendPkt(0, 8'h11, 5, 8'hF0, "R5");
      sendPkt(1, 8'h12, 5, 8'hF1, "R5");
      sendPkt(2, 8'h13, 5, 8'hF2, "R5");
      sendPkt(3, 8'h10, 5, 8'hF3, "R5");
    join
    for (int p = 1; p < PORT_CNT; p++)
      chk("R5", $sformatf("header cycle input %0d", p), 32'(hdrCyc[p]), 32'(hdrCyc[0]));
    tick(2);

    // R8: stalled output holds its word and stalls its input
    outReady[2] = 1'b0;
    fork
      sendPkt(0, 8'h12, 3, 8'h5A, "R8");
      begin
        repeat (3) begin
          @(negedge clk);
          #0.5;
          chk("R8", "input stalled", 32'(inReady[0]), 32'd0);
          chk("R8", "valid held", 32'(outValid[2]), 32'd1);
          chk("R8", "data held", outData[2], {8'h12, 8'h00, 16'd3});
        end
        tick(1);
        outReady[2] = 1'b1;
        tick(2);
        outReady[2] = 1'b0;
        tick(2);
        chk("R8", "mid-packet stall", 32'(inReady[0]), 32'd0);
        outReady[2] = 1'b1;
      end
    join
    tick(5);
    for (int o = 0; o < PORT_CNT; o++)
      chk("R8", $sformatf("words left for port %0d", o), 32'(expQ[o].size()), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule